// File: doc/BRIEF.md
# Extended-Precision Accumulator Add/Subtract Unit

This unit performs the additive operations of a datapath with a 56-bit accumulator and 24-bit data registers. It takes a 48-bit operand made by joining a high and a low data register, sign-extends it to accumulator width, and adds it to the current accumulator or subtracts it. It can also add or subtract a second full-width accumulator.

Two chained forms add in, or take away, a carry/borrow flag kept from the previous arithmetic operation. Software can therefore build sums and differences wider than one accumulator by issuing one operation per word, lowest word first. When the enable strobe is high at a rising edge, the result and the flag are both registered on that edge.

Top module: `acc_carry_unit`

## Requirements
- R1: While reset is active, and until the internal release completes two clock edges after `rst_n` rises, `acc_o` is 0 and `carry_o` is 0.
- R2: Op code 0 (add pair) with `en_i` high sets `acc_o` to `acc_i` plus the extended pair, modulo 2^56. `carry_o` becomes the carry out of bit 55.
- R3: Op code 1 (subtract pair) sets `acc_o` to `acc_i` minus the extended pair, modulo 2^56. `carry_o` becomes 1 exactly when `acc_i` is less than the extended pair, both read as unsigned 56-bit values.
- R4: Op code 2 (add accumulator) sets `acc_o` to `acc_i + acc_src_i` modulo 2^56. `carry_o` is the carry out of bit 55.
- R5: Op code 3 (subtract accumulator) sets `acc_o` to `acc_i - acc_src_i` modulo 2^56. `carry_o` is 1 exactly when `acc_i < acc_src_i` (unsigned).
- R6: Op code 4 (add with carry) adds the extended pair plus the current `carry_o` to `acc_i`. The new `carry_o` is the carry out of bit 55.
- R7: Op code 5 (subtract with borrow) subtracts the extended pair and the current `carry_o` from `acc_i`. The new `carry_o` is 1 exactly when `acc_i` is less than the extended pair plus the old flag (unsigned).
- R8: The extended pair is `{hi_i, lo_i}`, with bit 23 of `hi_i` copied into bits 55..48.
- R9: When `en_i` is low at a rising edge, `acc_o` and `carry_o` keep their values, whatever the other inputs are.
- R10: Op codes 6 and 7 with `en_i` high leave `acc_o` and `carry_o` unchanged.
- R11: Results and the flag appear one clock after the edge that samples the operation, and they stay there until the next committed operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronized internally |
| en_i | input | 1 | Commit strobe for result and flag |
| op_i | input | 3 | Operation code (0..5 valid; 6 and 7 do nothing) |
| hi_i | input | 24 | High data register of the pair operand |
| lo_i | input | 24 | Low data register of the pair operand |
| acc_i | input | 56 | Accumulator being updated |
| acc_src_i | input | 56 | Second accumulator for the accumulator-to-accumulator forms |
| acc_o | output | 56 | Registered result |
| carry_o | output | 1 | Registered carry/borrow flag |

## Verification
The bench adds a negative pair to a small accumulator. If the extension fills the top byte with zeros instead of the sign, both the sum and the carry come out wrong. It also makes accumulator sums wrap at 2^56, which catches a carry taken from the wrong bit. Borrow cases include equal operands and an operand one larger than the accumulator, which catches a subtract that reports an inverted borrow. Chained add-with-carry and subtract-with-borrow sequences run with the flag both set and clear, so a design that ignores the stored flag, or takes it from the wrong operation, gives a result off by one. Idle cycles and reserved op codes are driven with busy inputs to catch a register that updates when it should hold.

// File: rtl/acu_pkg.sv
package acu_pkg;
  typedef enum logic [2:0] {
    OP_ADD_PAIR = 3'd0,
    OP_SUB_PAIR = 3'd1,
    OP_ADD_ACC  = 3'd2,
    OP_SUB_ACC  = 3'd3,
    OP_ADD_CY   = 3'd4,
    OP_SUB_CY   = 3'd5
  } acu_op_e;
endpackage

// File: rtl/acu_rst_sync.sv
module acu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_ok = chain_q[STAGES-1];
endmodule

// File: rtl/acu_operand_sel.sv
module acu_operand_sel
  import acu_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int ACC_W  = 56
) (
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] hi_i,
  input  logic [DATA_W-1:0] lo_i,
  input  logic [ACC_W-1:0]  acc_src_i,
  output logic [ACC_W-1:0]  opnd_o,
  output logic              sub_o,
  output logic              use_flag_o,
  output logic              valid_o
);
  localparam int PAIR_W = 2 * DATA_W;
  localparam int EXT_W  = ACC_W - PAIR_W;

  logic [ACC_W-1:0] pair_ext;

  generate
    if (EXT_W > 0) begin : g_ext
      assign pair_ext = {{EXT_W{hi_i[DATA_W-1]}}, hi_i, lo_i};
    end else begin : g_noext
      assign pair_ext = ACC_W'({hi_i, lo_i});
    end
  endgenerate

  always_comb begin
    opnd_o     = pair_ext;
    sub_o      = 1'b0;
    use_flag_o = 1'b0;
    valid_o    = 1'b1;
    case (acu_op_e'(op_i))
      OP_ADD_PAIR: ;
      OP_SUB_PAIR: sub_o = 1'b1;
      OP_ADD_ACC:  opnd_o = acc_src_i;
      OP_SUB_ACC: begin
        opnd_o = acc_src_i;
        sub_o  = 1'b1;
      end
      OP_ADD_CY:   use_flag_o = 1'b1;
      OP_SUB_CY: begin
        sub_o      = 1'b1;
        use_flag_o = 1'b1;
      end
      default:     valid_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/acu_addsub.sv
module acu_addsub #(
  parameter int ACC_W = 56
) (
  input  logic [ACC_W-1:0] a_i,
  input  logic [ACC_W-1:0] b_i,
  input  logic             sub_i,
  input  logic             flag_i,
  output logic [ACC_W-1:0] res_o,
  output logic             flag_o
);
  localparam int SUM_W = ACC_W + 1;

  logic [ACC_W-1:0] b_eff;
  logic             cin;
  logic [SUM_W-1:0] sum;

  always_comb begin
    b_eff  = sub_i ? ~b_i : b_i;
    cin    = sub_i ? ~flag_i : flag_i;
    sum    = {1'b0, a_i} + {1'b0, b_eff} + SUM_W'(cin);
    res_o  = sum[ACC_W-1:0];
    flag_o = sub_i ? ~sum[ACC_W] : sum[ACC_W];
  end
endmodule

// File: rtl/acc_carry_unit.sv
module acc_carry_unit #(
  parameter int DATA_W = 24,
  parameter int ACC_W  = 56
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] hi_i,
  input  logic [DATA_W-1:0] lo_i,
  input  logic [ACC_W-1:0]  acc_i,
  input  logic [ACC_W-1:0]  acc_src_i,
  output logic [ACC_W-1:0]  acc_o,
  output logic              carry_o
);
  logic             rst_ok;
  logic [ACC_W-1:0] opnd;
  logic             sub;
  logic             use_flag;
  logic             op_valid;
  logic [ACC_W-1:0] sum;
  logic             flag_out;
  logic [ACC_W-1:0] acc_d, acc_q;
  logic             cy_d, cy_q;
  logic             commit;

  acu_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ok (rst_ok)
  );

  acu_operand_sel #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_sel (
    .op_i       (op_i),
    .hi_i       (hi_i),
    .lo_i       (lo_i),
    .acc_src_i  (acc_src_i),
    .opnd_o     (opnd),
    .sub_o      (sub),
    .use_flag_o (use_flag),
    .valid_o    (op_valid)
  );

  acu_addsub #(.ACC_W(ACC_W)) u_core (
    .a_i    (acc_i),
    .b_i    (opnd),
    .sub_i  (sub),
    .flag_i (use_flag & cy_q),
    .res_o  (sum),
    .flag_o (flag_out)
  );

  always_comb begin
    commit = en_i & op_valid;
    acc_d  = acc_q;
    cy_d   = cy_q;
    if (commit) begin
      acc_d = sum;
      cy_d  = flag_out;
    end
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      acc_q <= '0;
      cy_q  <= 1'b0;
    end else begin
      acc_q <= acc_d;
      cy_q  <= cy_d;
    end
  end

  assign acc_o   = acc_q;
  assign carry_o = cy_q;
endmodule

// File: rtl/acu_chk.sv
module acu_chk #(
  parameter int DATA_W = 24,
  parameter int ACC_W  = 56
) (
  input logic              clk,
  input logic              rst_ok,
  input logic              en_i,
  input logic [2:0]        op_i,
  input logic [DATA_W-1:0] hi_i,
  input logic [DATA_W-1:0] lo_i,
  input logic [ACC_W-1:0]  acc_i,
  input logic [ACC_W-1:0]  acc_src_i,
  input logic [ACC_W-1:0]  acc_o,
  input logic              carry_o
);
  localparam int EXT_W = ACC_W - 2 * DATA_W;

  logic [ACC_W-1:0] pair_x;
  assign pair_x = {{EXT_W{hi_i[DATA_W-1]}}, hi_i, lo_i};

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_ok |-> (acc_o == '0 && !carry_o));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    !en_i |=> ($stable(acc_o) && $stable(carry_o)));

  // R10
  reserved_op_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (en_i && op_i[2:1] == 2'b11) |=> ($stable(acc_o) && $stable(carry_o)));

  // R2
  add_pair_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (en_i && op_i == 3'd0) |=> (acc_o == $past(acc_i + pair_x)));

  // R4
  add_acc_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (en_i && op_i == 3'd2) |=> (acc_o == $past(acc_i + acc_src_i)));

  // R6
  add_cy_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (en_i && op_i == 3'd4) |=> (acc_o == $past(acc_i + pair_x + ACC_W'(carry_o))));

  // R5
  sub_acc_borrow_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (en_i && op_i == 3'd3) |=> (carry_o == $past(acc_i < acc_src_i)));
endmodule

bind acc_carry_unit acu_chk #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_chk (
  .clk       (clk),
  .rst_ok    (rst_ok),
  .en_i      (en_i),
  .op_i      (op_i),
  .hi_i      (hi_i),
  .lo_i      (lo_i),
  .acc_i     (acc_i),
  .acc_src_i (acc_src_i),
  .acc_o     (acc_o),
  .carry_o   (carry_o)
);

// File: tb/acc_carry_unit_test.sv
`timescale 1ns/1ps
module acc_carry_unit_test;
  localparam int DW = 24;
  localparam int AW = 56;

  logic          clk = 1'b0;
  logic          rst_n = 1'b1;
  logic          en_i = 1'b0;
  logic [2:0]    op_i = 3'd0;
  logic [DW-1:0] hi_i = '0;
  logic [DW-1:0] lo_i = '0;
  logic [AW-1:0] acc_i = '0;
  logic [AW-1:0] acc_src_i = '0;
  logic [AW-1:0] acc_o;
  logic          carry_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct {
    logic [AW-1:0] acc;
    logic          cy;
    string         tag;
  } exp_t;

  exp_t sb[$];
  exp_t cur;
  logic [AW-1:0] m_acc = '0;
  logic          m_cy  = 1'b0;

  always #5 clk = ~clk;

  acc_carry_unit uut (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .op_i(op_i),
    .hi_i(hi_i), .lo_i(lo_i), .acc_i(acc_i), .acc_src_i(acc_src_i),
    .acc_o(acc_o), .carry_o(carry_o)
  );

  task automatic check(input string tag, input logic [AW-1:0] ea, input logic ec);
    checks++;
    if (acc_o !== ea || carry_o !== ec) begin
      errors++;
      $display("FAIL %s: acc=%h carry=%b expected acc=%h carry=%b",
               tag, acc_o, carry_o, ea, ec);
    end
  endtask

  // scoreboard driver: applies one operation and queues its expected outcome
  task automatic drive(input logic en, input logic [2:0] op, input logic [DW-1:0] hi,
                       input logic [DW-1:0] lo, input logic [AW-1:0] a,
                       input logic [AW-1:0] s, input string tag);
    logic [AW-1:0] px;
    logic [AW-1:0] b;
    logic [AW:0]   wide;
    logic          fl;
    @(negedge clk);
    en_i = en; op_i = op; hi_i = hi; lo_i = lo; acc_i = a; acc_src_i = s;
    px = {{(AW-2*DW){hi[DW-1]}}, hi, lo};  // R8 sign extension
    b  = (op == 3'd2 || op == 3'd3) ? s : px;
    fl = (op == 3'd4 || op == 3'd5) ? m_cy : 1'b0;
    if (en && op <= 3'd5) begin
      if (op == 3'd0 || op == 3'd2 || op == 3'd4) begin
        wide  = {1'b0, a} + {1'b0, b} + {{AW{1'b0}}, fl};
        m_acc = wide[AW-1:0];
        m_cy  = wide[AW];
      end else begin
        m_acc = a - b - {{(AW-1){1'b0}}, fl};
        m_cy  = ({1'b0, a} < ({1'b0, b} + {{AW{1'b0}}, fl}));
      end
    end
    sb.push_back('{m_acc, m_cy, tag});
  endtask

  // scoreboard monitor: compares one result per cycle, after the edge (R11)
  always @(posedge clk) begin
    #2;
    if (sb.size() > 0) begin
      cur = sb.pop_front();
      check(cur.tag, cur.acc, cur.cy);
    end
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: acc=%h carry=%b expected completion", acc_o, carry_o);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 in reset", '0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 during release", '0, 1'b0);
    repeat (3) @(negedge clk);

    drive(1, 3'd0, 24'h000001, 24'h000002, 56'h10, '0, "R2 add pair small");
    drive(1, 3'd0, 24'hFFFFFF, 24'hFFFFFF, 56'h5, '0, "R2/R8 add negative pair");
    drive(1, 3'd0, 24'h800000, 24'h000000, 56'h0, '0, "R8 sign fill");
    drive(1, 3'd1, 24'h000000, 24'h000003, 56'h5, '0, "R3 sub no borrow");
    drive(1, 3'd1, 24'h000000, 24'h000005, 56'h3, '0, "R3 sub with borrow");
    drive(1, 3'd1, 24'h000000, 24'h000007, 56'h7, '0, "R3 sub equal");
    drive(1, 3'd2, '0, '0, {AW{1'b1}}, 56'h1, "R4 add acc wrap");
    drive(1, 3'd6, 24'h123456, 24'h654321, 56'h99, 56'h77, "R10 op6 hold");
    drive(1, 3'd4, 24'h000000, 24'h000010, 56'h100, '0, "R6 add carry set");
    drive(1, 3'd4, 24'h000000, 24'h000010, 56'h100, '0, "R6 add carry clear");
    drive(1, 3'd3, '0, '0, 56'h20, 56'h21, "R5 sub acc borrow");
    drive(0, 3'd0, 24'hABCDEF, 24'h123456, 56'hFFFF, 56'h1, "R9 idle hold");
    drive(1, 3'd5, 24'h000000, 24'h000001, 56'h10, '0, "R7 sub borrow set");
    drive(1, 3'd5, 24'h000000, 24'h000001, 56'h10, '0, "R7 sub borrow clear");
    drive(1, 3'd3, '0, '0, 56'h50, 56'h20, "R5 sub acc plain");
    drive(1, 3'd5, 24'h000000, 24'h000010, 56'h10, '0, "R7 equal no borrow");
    drive(1, 3'd7, 24'hFFFFFF, 24'h000000, 56'h1, 56'h1, "R10 op7 hold");
    drive(1, 3'd2, '0, '0, 56'h80_0000_0000_0000, 56'h80_0000_0000_0000, "R4 top carry");
    drive(1, 3'd4, 24'h000000, 24'h000000, 56'h0, '0, "R6 carry only");
    drive(0, 3'd4, 24'h000001, 24'h000001, 56'h1, '0, "R9 idle after chain");
    drive(0, 3'd0, '0, '0, '0, '0, "R11 result stays");
    repeat (3) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule